// File: doc/BRIEF.md
# Four-Digit Cycling Display Sequencer

This block steps through a fixed list of four decimal digits and shows the current one on a single seven-segment display. Each of the four positions holds one digit value, set by a parameter. While the advance input is high, the sequencer moves one position on every rising clock edge and returns to the first position after the fourth. While the advance input is low, nothing changes.

The block is a Moore machine. Its outputs are the 4-bit BCD code of the current digit, the seven segment drive lines decoded from that code, and the two state bits, which are brought out so the position can be watched during bring-up. All outputs depend only on the registered state, so they change only just after a clock edge. A synchronous active-low reset returns the machine to the first position. The digit parameters are checked at elaboration and must each lie in the range 0 to 9.

Top module: `digit_cycle_display`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state becomes 00 after that edge, whatever the value of `en`.
- R2: When `rst_n` is high and `en` is high at a rising edge, the state advances by one in the order 00, 01, 10, 11 and then back to 00.
- R3: When `rst_n` is high and `en` is low at a rising edge, `state_q`, `bcd` and `seg` keep their values across that edge.
- R4: `bcd` equals the digit parameter of the current position: DIGIT0 for state 00, DIGIT1 for 01, DIGIT2 for 10 and DIGIT3 for 11. Bit 3 is 1 only for digits 8 and 9.
- R5: The outputs depend only on the state. A change of `en` between clock edges leaves `state_q`, `bcd` and `seg` unchanged.
- R6: `seg` is active high with bit 0 = segment a through bit 6 = segment g. It shows the decimal value of `bcd`: 0→7'h3F, 1→7'h06, 2→7'h5B, 3→7'h4F, 4→7'h66, 5→7'h6D, 6→7'h7D, 7→7'h07, 8→7'h7F, 9→7'h6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; returns to state 00 |
| en | input | 1 | Advance enable; high steps one position per edge, low holds |
| bcd | output | 4 | BCD code of the digit at the current position |
| state_q | output | 2 | Current state bits, for debug observation |
| seg | output | 7 | Segment drive, active high, bit 0 = a through bit 6 = g |

## Verification
There is one register stage: an edge that samples `en` or `rst_n` produces the new state, and the combinational `bcd` and `seg` follow it in the same cycle. So every result is due just after the edge that sampled the stimulus. The bench drives inputs on the falling edge, updates its model at the rising edge and compares all outputs at the next falling edge. For R5 it also flips `en` between edges and checks that the outputs have not moved before the next rising edge. Three instances with different digit parameters together cover all ten segment patterns.

// File: rtl/seqdisp_pkg.sv
// Package seqdisp_pkg
// Shared widths and types for the digit cycling display.
// Assumes four positions, BCD digits and a single 7-segment display.
package seqdisp_pkg;
    localparam int NUM_POS = 4;
    localparam int STATE_W = $clog2(NUM_POS);
    localparam int BCD_W   = 4;
    localparam int SEG_W   = 7;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [BCD_W-1:0]   bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/pos_sequencer.sv
// Module pos_sequencer
// Holds the position register. It advances by one on each enabled edge
// and wraps after NUM_STATES-1. Reset is synchronous and active low and
// takes priority over enable.
// Assumes NUM_STATES >= 2.
module pos_sequencer #(
    parameter int NUM_STATES = 4,
    localparam int W = $clog2(NUM_STATES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] state_q
);
    localparam logic [W-1:0] LAST = W'(NUM_STATES - 1);

    logic [W-1:0] state_nxt;

    // Next position: step with wrap when enabled, otherwise hold
    always_comb begin
        state_nxt = state_q;
        if (en) begin
            state_nxt = (state_q == LAST) ? '0 : state_q + W'(1);
        end
    end

    // Position register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_nxt;
    end
endmodule

// File: rtl/digit_table.sv
// Module digit_table
// Maps a position to its BCD digit. The digits are packed into
// DIGIT_VEC, with position k in bits [4k+3:4k].
// Assumes the caller has range-checked each digit.
module digit_table #(
    parameter int NUM_POS = 4,
    parameter logic [NUM_POS*4-1:0] DIGIT_VEC = '0,
    localparam int W = $clog2(NUM_POS)
) (
    input  logic [W-1:0] pos,
    output logic [3:0]   digit
);
    logic [3:0] lut [NUM_POS];

    for (genvar k = 0; k < NUM_POS; k++) begin : g_entry
        assign lut[k] = DIGIT_VEC[k*4 +: 4];
    end

    // Select the digit of the current position
    always_comb begin
        digit = lut[pos];
    end
endmodule

// File: rtl/bcd_seg_decoder.sv
// Module bcd_seg_decoder
// Turns a BCD code into active-high segment lines, bit 0 = a up to
// bit 6 = g. Codes 10 to 15 blank the display.
// Assumes a plain single-digit display with no decimal point.
module bcd_seg_decoder
    import seqdisp_pkg::*;
(
    input  bcd_t code,
    output seg_t seg
);
    // Segment pattern for each decimal value
    always_comb begin
        unique case (code)
            4'd0:    seg = 7'b0111111;
            4'd1:    seg = 7'b0000110;
            4'd2:    seg = 7'b1011011;
            4'd3:    seg = 7'b1001111;
            4'd4:    seg = 7'b1100110;
            4'd5:    seg = 7'b1101101;
            4'd6:    seg = 7'b1111101;
            4'd7:    seg = 7'b0000111;
            4'd8:    seg = 7'b1111111;
            4'd9:    seg = 7'b1101111;
            default: seg = 7'b0000000;
        endcase
    end
endmodule

// File: rtl/digit_cycle_display.sv
// Module digit_cycle_display
// Top level. A Moore machine cycles through four parameterized decimal
// digits while en is high and drives one seven-segment display.
// Assumes each DIGITn lies in 0..9 (checked at elaboration).
module digit_cycle_display
    import seqdisp_pkg::*;
#(
    parameter int DIGIT0 = 5,
    parameter int DIGIT1 = 8,
    parameter int DIGIT2 = 0,
    parameter int DIGIT3 = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic [BCD_W-1:0]   bcd,
    output logic [STATE_W-1:0] state_q,
    output logic [SEG_W-1:0]   seg
);
    localparam logic [NUM_POS*4-1:0] DIGIT_VEC =
        {DIGIT3[3:0], DIGIT2[3:0], DIGIT1[3:0], DIGIT0[3:0]};

    if (DIGIT0 < 0 || DIGIT0 > 9 || DIGIT1 < 0 || DIGIT1 > 9 ||
        DIGIT2 < 0 || DIGIT2 > 9 || DIGIT3 < 0 || DIGIT3 > 9) begin : g_bad_digit
        $error("digit_cycle_display: every DIGITn must be within 0..9");
    end

    state_t pos_w;
    bcd_t   digit_w;
    seg_t   seg_w;

    pos_sequencer #(.NUM_STATES(NUM_POS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .state_q (pos_w)
    );

    digit_table #(.NUM_POS(NUM_POS), .DIGIT_VEC(DIGIT_VEC)) u_tab (
        .pos   (pos_w),
        .digit (digit_w)
    );

    bcd_seg_decoder u_dec (
        .code (digit_w),
        .seg  (seg_w)
    );

    assign state_q = pos_w;
    assign bcd     = digit_w;
    assign seg     = seg_w;
endmodule

// File: rtl/seq_display_checker.sv
// Module seq_display_checker
// Temporal properties of the digit cycling display, bound to the top.
// Assumes the port widths of digit_cycle_display.
module seq_display_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [3:0] bcd,
    input logic [1:0] state_q,
    input logic [6:0] seg
);
    // R1: the first enabled-out-of-reset cycle starts at position 00
    p_reset_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_q == 2'b00);

    // R2: an enabled edge steps the position by one with wrap
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> state_q == 2'($past(state_q) + 2'd1));

    // R3: a disabled edge leaves every output unchanged
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state_q) && $stable(bcd) && $stable(seg)));

    // R4: the digit code is always a decimal digit
    p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bcd <= 4'd9);

    // R6: an eight lights all segments, a one lights exactly two
    p_seg_eight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd == 4'd8) |-> $countones(seg) == 7);
    p_seg_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd == 4'd1) |-> $countones(seg) == 2);
endmodule

bind digit_cycle_display seq_display_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .bcd     (bcd),
    .state_q (state_q),
    .seg     (seg)
);

// File: tb/tb_digit_cycle_display.sv
module tb_digit_cycle_display;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] exp_state = 2'b00;

    always #10 clk = ~clk;

    logic [3:0] bcd_a, bcd_b, bcd_c;
    logic [1:0] st_a, st_b, st_c;
    logic [6:0] seg_a, seg_b, seg_c;

    // Three instances cover all ten digits between them
    digit_cycle_display #(.DIGIT0(5), .DIGIT1(8), .DIGIT2(0), .DIGIT3(9)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .bcd(bcd_a), .state_q(st_a), .seg(seg_a));
    digit_cycle_display #(.DIGIT0(1), .DIGIT1(2), .DIGIT2(3), .DIGIT3(4)) dut_b (
        .clk(clk), .rst_n(rst_n), .en(en), .bcd(bcd_b), .state_q(st_b), .seg(seg_b));
    digit_cycle_display #(.DIGIT0(6), .DIGIT1(7), .DIGIT2(7), .DIGIT3(6)) dut_c (
        .clk(clk), .rst_n(rst_n), .en(en), .bcd(bcd_c), .state_q(st_c), .seg(seg_c));

    function automatic logic [3:0] digit_of(int inst, logic [1:0] s);
        int tab [3][4] = '{'{5, 8, 0, 9}, '{1, 2, 3, 4}, '{6, 7, 7, 6}};
        return 4'(tab[inst][s]);
    endfunction

    function automatic logic [6:0] seg_of(logic [3:0] d);
        case (d)
            4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
            4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
            4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
            4'd9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output of every instance against the model
    task automatic check_all(string req);
        cmp(req, "state a", st_a, exp_state);
        cmp(req, "state b", st_b, exp_state);
        cmp(req, "state c", st_c, exp_state);
        cmp("R4", "bcd a", bcd_a, digit_of(0, exp_state));
        cmp("R4", "bcd b", bcd_b, digit_of(1, exp_state));
        cmp("R4", "bcd c", bcd_c, digit_of(2, exp_state));
        cmp("R6", "seg a", seg_a, seg_of(digit_of(0, exp_state)));
        cmp("R6", "seg b", seg_b, seg_of(digit_of(1, exp_state)));
        cmp("R6", "seg c", seg_c, seg_of(digit_of(2, exp_state)));
    endtask

    // One clock: drive on falling edge, model at rising, check at falling
    task automatic cycle(logic r, logic e, string req);
        rst_n = r;
        en = e;
        @(posedge clk);
        if (!r)     exp_state = 2'b00;
        else if (e) exp_state = exp_state + 2'd1;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset holds the start position even with en high
        cycle(1'b0, 1'b1, "R1");
        cycle(1'b0, 1'b0, "R1");
        cycle(1'b0, 1'b1, "R1");
        // R2: two full laps with wrap from 11 to 00
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, "R2");
        // R3: hold for several cycles
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R3");
        // R3/R2: single-cycle enable pulses
        cycle(1'b1, 1'b1, "R2"); cycle(1'b1, 1'b0, "R3"); cycle(1'b1, 1'b0, "R3");
        cycle(1'b1, 1'b1, "R2"); cycle(1'b1, 1'b0, "R3");
        // R5: toggle en between edges, outputs must not move
        for (int i = 0; i < 4; i++) begin
            en = ~en;
            #3;
            check_all("R5");
            en = ~en;
            #3;
            check_all("R5");
            cycle(1'b1, 1'b1, "R2");
        end
        // R1: reset in the middle of a run
        cycle(1'b1, 1'b1, "R2");
        cycle(1'b0, 1'b1, "R1");
        // Random enable with occasional reset
        for (int i = 0; i < 300; i++) begin
            logic r;
            logic e;
            r = ($urandom % 25) != 0;
            e = 1'($urandom % 2);
            cycle(r, e, !r ? "R1" : (e ? "R2" : "R3"));
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule